// File: doc/BRIEF.md
# Three-Round-Per-Clock RC5 Block Encryptor

This block turns a 64-bit plaintext, treated as a pair of 32-bit words, into a 64-bit ciphertext using the RC5 cipher with 32-bit words and 15 rounds. The round subkeys come from an on-chip table of 32 expanded-key words, which key expansion logic fills. That logic sits outside this block. The block never stores the key itself. It addresses the table one group at a time. The table returns eight consecutive words per group over one wide, combinational read port.

Three rounds are chained inside one clock cycle, so a block needs five working cycles. A cycle counts as working only when the `start` level is high and the key table is marked ready. The first working cycle of a block takes in the plaintext, adds the whitening subkeys and runs rounds 1 to 3. Each later working cycle runs the next three rounds. When `start` stays high the whole time, a finished ciphertext appears every five cycles. When `start` is low the block keeps its state unchanged.

Top module: `blk_cipher_enc3`

## Requirements
- R1: After reset, `ct_valid` is 0, `key_addr` is 0 and `ciphertext` is all zeros.
- R2: The word A is bits [31:0] of the plaintext and B is bits [63:32]. The ciphertext packs A and B in the same positions. Before the rounds, A = A + S[0] and B = B + S[1]. Round i, for i = 1 to 15, computes A = ((A xor B) rotated left by B[4:0]) + S[2i] and then B = ((B xor A) rotated left by A[4:0]) + S[2i+1]. All additions are modulo 2^32.
- R3: In a given cycle, `key_addr` = g selects group g. In that group, bits [32j+31:32j] of `key_data` must hold S[6g+j] for j = 0 to 7. Whitening uses words 0 and 1 only in group 0. Every group uses words 2 to 7 for its three rounds.
- R4: A cycle is working only when `start` and `key_ready` are both 1. While `key_ready` is 0, `start` has no effect on any output.
- R5: `ct_valid` goes high right after the fifth working edge of a block. With `start` held high, one block completes every five clock cycles.
- R6: While `start` is low, `ciphertext`, `key_addr` and `ct_valid` hold their values.
- R7: The plaintext is sampled only on the first working edge of a block. Changes to it during later cycles of the block do not affect the result.
- R8: After a block completes, `ct_valid` and `ciphertext` hold until the next working edge. That edge takes in a new plaintext and clears `ct_valid`.
- R9: `key_addr` advances 0, 1, 2, 3, 4 on successive working edges and returns to 0 after 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_ready | input | 1 | Expanded-key table is complete |
| start | input | 1 | Level; each working edge runs three rounds |
| plaintext | input | 64 | Plaintext block, word A in [31:0] |
| key_addr | output | 3 | Subkey group index |
| key_data | input | 256 | Eight subkey words of the selected group |
| ciphertext | output | 64 | Round state; the ciphertext once `ct_valid` is high |
| ct_valid | output | 1 | Ciphertext is complete |

## Verification
The bench streams blocks back to back with `start` held high, including all-zero and all-one plaintexts. A design that dropped a round, used the wrong subkey group or mixed up the word order would give the wrong ciphertext, and a counter that stopped one group early or late would raise `ct_valid` in the wrong cycle. In one block `start` is pulled low for several cycles midway. A design that kept advancing would skip subkeys, and one that lost its state would restart the block. In another block the plaintext is changed after the first edge, which exposes a design that samples it more than once. The bench also raises `start` before `key_ready` is set, and leaves a finished result waiting with `start` low. This catches a block that runs on an unfilled table, or one that drops or overwrites a ciphertext nobody has collected yet.

// File: rtl/blk_cipher_enc3.sv
module blk_cipher_enc3 #(
  parameter int W      = 32,
  parameter int ROUNDS = 15,
  parameter int RPC    = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    key_ready,
  input  logic                    start,
  input  logic [2*W-1:0]          plaintext,
  output logic [$clog2(ROUNDS/RPC)-1:0] key_addr,
  input  logic [(2*RPC+2)*W-1:0]  key_data,
  output logic [2*W-1:0]          ciphertext,
  output logic                    ct_valid
);
  localparam int GROUPS = ROUNDS / RPC;
  localparam int GW     = $clog2(GROUPS);
  localparam int SH     = $clog2(W);
  localparam logic [GW-1:0] LAST = GW'(GROUPS - 1);

  logic [W-1:0]  a_q, b_q;
  logic [GW-1:0] grp_q;
  logic          vld_q;
  logic          go;
  logic [W-1:0]  a_c [0:RPC];
  logic [W-1:0]  b_c [0:RPC];

  function automatic logic [W-1:0] rotl(input logic [W-1:0] x, input logic [SH-1:0] s);
    logic [2*W-1:0] t;
    t = {x, x} << s;
    return t[2*W-1:W];
  endfunction

  assign go = start & key_ready;

  assign a_c[0] = (grp_q == '0) ? plaintext[W-1:0] + key_data[0 +: W] : a_q;
  assign b_c[0] = (grp_q == '0) ? plaintext[2*W-1:W] + key_data[W +: W] : b_q;

  for (genvar r = 0; r < RPC; r++) begin : g_round
    assign a_c[r+1] = rotl(a_c[r] ^ b_c[r], b_c[r][SH-1:0]) + key_data[(2*r+2)*W +: W];
    assign b_c[r+1] = rotl(b_c[r] ^ a_c[r+1], a_c[r+1][SH-1:0]) + key_data[(2*r+3)*W +: W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      grp_q <= '0;
      vld_q <= 1'b0;
    end else if (go) begin
      a_q   <= a_c[RPC];
      b_q   <= b_c[RPC];
      grp_q <= (grp_q == LAST) ? '0 : grp_q + 1'b1;
      vld_q <= (grp_q == LAST);
    end
  end

  assign key_addr   = grp_q;
  assign ciphertext = {b_q, a_q};
  assign ct_valid   = vld_q;
endmodule

// File: rtl/blk_cipher_enc3_chk.sv
module blk_cipher_enc3_chk #(
  parameter int AW    = 3,
  parameter int LASTG = 4,
  parameter int DW    = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          key_ready,
  input logic [AW-1:0] key_addr,
  input logic [DW-1:0] ciphertext,
  input logic          ct_valid
);
  logic go;
  assign go = start & key_ready;

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> ($stable(ciphertext) && $stable(key_addr) && $stable(ct_valid))); // R6

  AST_NOKEY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !key_ready) |=> ($stable(key_addr) && $stable(ct_valid))); // R4

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    key_addr <= AW'(LASTG)); // R9

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (($past(key_addr) == AW'(LASTG)) ? (key_addr == '0)
                                            : (key_addr == AW'($past(key_addr) + 1'b1)))); // R9

  AST_VALID_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (go && key_addr == AW'(LASTG)) |=> ct_valid); // R5

  AST_VALID_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (go && key_addr != AW'(LASTG)) |=> !ct_valid); // R8

  AST_VALID_GROUP0: assert property (@(posedge clk) disable iff (!rst_n)
    ct_valid |-> (key_addr == '0)); // R5
endmodule

bind blk_cipher_enc3 blk_cipher_enc3_chk #(.AW(GW), .LASTG(GROUPS - 1), .DW(2 * W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .key_ready(key_ready),
  .key_addr(key_addr), .ciphertext(ciphertext), .ct_valid(ct_valid)
);

// File: tb/blk_cipher_enc3_test.sv
module blk_cipher_enc3_test;
  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         key_ready;
  logic         start;
  logic [63:0]  plaintext;
  logic [2:0]   key_addr;
  logic [255:0] key_data;
  logic [63:0]  ciphertext;
  logic         ct_valid;

  logic [31:0] tbl [0:31];
  logic [63:0] exp_q [$];
  int total = 0;
  int bad = 0;
  bit prev_done = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  blk_cipher_enc3 uut (
    .clk(clk), .rst_n(rst_n), .key_ready(key_ready), .start(start),
    .plaintext(plaintext), .key_addr(key_addr), .key_data(key_data),
    .ciphertext(ciphertext), .ct_valid(ct_valid)
  );

  always_comb begin
    for (int j = 0; j < 8; j++)
      key_data[j*32 +: 32] = tbl[(int'(key_addr) * 6 + j) % 32];
  end

  function automatic logic [31:0] rol(input logic [31:0] x, input int s);
    if (s == 0) return x;
    return (x << s) | (x >> (32 - s));
  endfunction

  function automatic logic [63:0] ref_enc(input logic [63:0] pt);
    logic [31:0] a, b;
    a = pt[31:0] + tbl[0];
    b = pt[63:32] + tbl[1];
    for (int i = 1; i <= 15; i++) begin
      a = rol(a ^ b, int'(b[4:0])) + tbl[2*i];
      b = rol(b ^ a, int'(a[4:0])) + tbl[2*i+1];
    end
    return {b, a};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_block(input logic [63:0] pt, input int stall_at, input bit mutate);
    logic [63:0] hold_ct;
    logic [2:0]  hold_addr;
    exp_q.push_back(ref_enc(pt));
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (k == stall_at) begin
        start = 1'b0;
        hold_ct = ciphertext;
        hold_addr = key_addr;
        repeat (3) begin
          @(negedge clk);
          check(ciphertext == hold_ct, "R6 ciphertext during stall", ciphertext, hold_ct);
          check(key_addr == hold_addr, "R6 key_addr during stall", 64'(key_addr), 64'(hold_addr));
        end
      end
      check(key_addr == 3'(k), "R9 group index", 64'(key_addr), 64'(k));
      if (k == 0)
        check(ct_valid == prev_done, "R5/R8 valid before first edge", 64'(ct_valid), 64'(prev_done));
      else
        check(ct_valid == 1'b0, "R8 valid cleared mid-block", 64'(ct_valid), 64'd0);
      plaintext = (mutate && k > 0) ? ~pt : pt;
      start = 1'b1;
    end
    prev_done = 1'b1;
  endtask

  task automatic idle_after(input int n);
    logic [63:0] hold_ct;
    @(negedge clk);
    check(ct_valid == 1'b1, "R5 valid after fifth edge", 64'(ct_valid), 64'd1);
    check(key_addr == 3'd0, "R9 group wraps to 0", 64'(key_addr), 64'd0);
    hold_ct = ciphertext;
    start = 1'b0;
    plaintext = 64'h5555_aaaa_0f0f_f0f0;
    repeat (n) begin
      @(negedge clk);
      check(ct_valid == 1'b1, "R8 valid held while idle", 64'(ct_valid), 64'd1);
      check(ciphertext == hold_ct, "R8 ciphertext held while idle", ciphertext, hold_ct);
    end
  endtask

  // monitor: scoreboard pop on each new valid result (R2, R3)
  initial begin
    bit seen = 0;
    logic [63:0] e;
    forever begin
      @(negedge clk);
      if (rst_n && ct_valid && !seen) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected result", ciphertext, 64'd0);
        end else begin
          e = exp_q.pop_front();
          check(ciphertext == e, "R2/R3 ciphertext", ciphertext, e);
        end
      end
      seen = ct_valid;
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++)
      tbl[i] = (32'h9e37_79b9 * 32'(i + 3)) ^ (32'h0000_1357 << (i % 19));
    rst_n = 1'b0;
    key_ready = 1'b0;
    start = 1'b0;
    plaintext = '0;
    repeat (3) @(negedge clk);
    check(ct_valid == 1'b0, "R1 valid at reset", 64'(ct_valid), 64'd0);
    check(key_addr == 3'd0, "R1 group at reset", 64'(key_addr), 64'd0);
    check(ciphertext == 64'd0, "R1 ciphertext at reset", ciphertext, 64'd0);
    rst_n = 1'b1;

    // R4: start without key_ready
    start = 1'b1;
    plaintext = 64'h1234_5678_9abc_def0;
    repeat (8) begin
      @(negedge clk);
      check(key_addr == 3'd0, "R4 no progress without key", 64'(key_addr), 64'd0);
      check(ct_valid == 1'b0, "R4 no valid without key", 64'(ct_valid), 64'd0);
      check(ciphertext == 64'd0, "R4 state untouched", ciphertext, 64'd0);
    end
    start = 1'b0;
    key_ready = 1'b1;

    run_block(64'h0, -1, 1'b0);
    run_block(64'hffff_ffff_ffff_ffff, -1, 1'b0);
    run_block(64'h0123_4567_89ab_cdef, -1, 1'b0);
    run_block(64'hdead_beef_0000_001f, 2, 1'b0);
    run_block(64'h8000_0001_7fff_fffe, -1, 1'b1);   // R7
    idle_after(4);
    run_block(64'hcafe_f00d_1357_9bdf, 0, 1'b0);    // R8 restart after idle
    idle_after(2);

    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R5 all results delivered", 64'(exp_q.size()), 64'd0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule